// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with DRAM Override

This block turns a 20-bit bus address into active-low chip selects. A programmable midrange memory block is split into four equal regions, each with its own select. A row of 256-byte peripheral windows sits at a programmable base, in either I/O or memory space. Two DRAM banks are decoded alongside them. Where a peripheral window overlaps a DRAM bank, the peripheral wins: the DRAM access is suppressed, and the wait-state count is raised to the larger of the two programmed counts. An upper-memory select covers everything at or above a programmable boundary. It is held negated when the upper DRAM function is enabled.

The address and space indicator are captured when the address-phase strobe is high, and the captured access drives the selects until the next strobe. Peripheral selects are the exception. While the strobe is high they follow the live address, so they are already valid during the multiplexed address phase. When the whole-block mode is set, the first midrange select covers the entire midrange block. The other three selects are then released for other uses and stay high. The block also reports the bus width of the winning midrange region and the wait-state count to apply.

Top module: `csdec_top`

## Requirements
- R1: While reset is active or hold is high, every select output is high (inactive) and `dram_act_o` is 0. This applies even when the strobe presents a matching address.
- R2: In memory space (`io_i`=0), midrange region k covers `mid_base_i + k*S` up to `mid_base_i + (k+1)*S - 1`, where S = 2^(9+`mid_sz_i`) bytes. `mid_cs_n_o[k]` goes low in the cycle after the strobe captures an address in region k. At most one midrange select is low at a time. An I/O access never matches.
- R3: With `mid_span_i`=1, `mid_cs_n_o[0]` is low for any address in the whole block (4*S bytes), and `mid_cs_n_o[3:1]` stay high.
- R4: `bus8_o` is 1 when the winning access is a midrange region whose `mid_w8_i` bit is 1 (bit k for region k, or bit 0 in whole-block mode), and 0 otherwise.
- R5: Peripheral window j covers `per_base_i + 256*j` up to `per_base_i + 256*j + 255` for j in 0..5. It drives `per_cs_n_o[j]` low only if `io_i` equals `per_io_i` (1 = I/O space).
- R6: While the strobe is high, the peripheral selects decode the live address in the same cycle, before the capturing clock edge.
- R7: When a captured access hits both a peripheral window and a DRAM bank, the peripheral select is asserted and `dram_act_o` stays 0.
- R8: On such an overlap, `ws_o` is the larger of `per_ws_i` and the wait-state count of that DRAM bank. A peripheral hit with no DRAM overlap gives `per_ws_i`.
- R9: `hi_cs_n_o` is low for a memory access at or above `hi_base_i`, with a wait-state count of `base_ws_i`. It stays high whenever `hi_dram_i`=1.
- R10: When nothing matches, all selects stay high, `dram_act_o` and `bus8_o` are 0, and `ws_o` equals `base_ws_i`.
- R11: A memory access inside an enabled DRAM bank b (base `dram_base_i[b]`, 2^`dram_sz_i[b]` bytes) with no peripheral hit sets `dram_act_o`=1 and `ws_o`=`dram_ws_i[b]`. The lowest-numbered matching bank wins.
- R12: A midrange hit with no peripheral or DRAM hit gives `ws_o`=`mid_ws_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Bus address |
| io_i | input | 1 | 1 = I/O space access, 0 = memory |
| aphase_i | input | 1 | Address-phase strobe; captures the access |
| hold_i | input | 1 | Bus hold granted; forces all selects inactive |
| mid_base_i | input | 20 | Midrange block base address |
| mid_sz_i | input | 3 | Region size code, region = 2^(9+code) bytes |
| mid_w8_i | input | 4 | Per-region 8-bit bus flag |
| mid_ws_i | input | 4 | Midrange wait states |
| mid_span_i | input | 1 | First select covers the whole midrange block |
| per_base_i | input | 20 | Peripheral block base address |
| per_io_i | input | 1 | Peripheral block lives in I/O space |
| per_ws_i | input | 4 | Peripheral wait states |
| dram_en_i | input | 2 | Per-bank DRAM enable |
| dram_base_i | input | 2x20 | Per-bank DRAM base |
| dram_sz_i | input | 2x5 | Per-bank log2 size in bytes |
| dram_ws_i | input | 2x4 | Per-bank DRAM wait states |
| hi_base_i | input | 20 | Lower boundary of upper memory |
| hi_dram_i | input | 1 | Upper DRAM function enabled; negates upper select |
| base_ws_i | input | 4 | Default wait-state count |
| mid_cs_n_o | output | 4 | Midrange selects, active low |
| per_cs_n_o | output | 6 | Peripheral selects, active low |
| hi_cs_n_o | output | 1 | Upper-memory select, active low |
| dram_act_o | output | 1 | DRAM access granted |
| bus8_o | output | 1 | Winning access is 8 bits wide |
| ws_o | output | 4 | Wait-state count to apply |

## Verification
The hardest situation to create is the same-cycle peripheral decode. It only shows between the strobe going high and the clock edge that captures the address, and during that window the other outputs still reflect the previous access. The bench first leaves a non-matching access latched. It then raises the strobe on a falling edge with a peripheral address and samples the peripheral selects before the next rising edge, while the midrange selects are still inactive. The overlap case needs a configuration where the DRAM bank's count exceeds the peripheral's, and then the reverse, so that the larger-of-two choice is seen from both sides.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
   // Fixed geometry of one peripheral window, in address bits.
   localparam int unsigned PER_WIN_SH = 8;
   // Smallest midrange region, in address bits.
   localparam int unsigned MID_MIN_SH = 9;
endpackage

// File: rtl/csdec_mid.sv
module csdec_mid #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned N_MID  = 4,
   parameter int unsigned SZ_W   = 3,
   parameter int unsigned MIN_SH = csdec_pkg::MID_MIN_SH
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              io_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [SZ_W-1:0]   sz_i,
   input  logic              span_i,
   input  logic [N_MID-1:0]  w8_i,
   output logic              hit_o,
   output logic [N_MID-1:0]  sel_o,
   output logic              b8_o
);
   localparam int unsigned IDX_W = $clog2(N_MID);

   if ((N_MID & (N_MID - 1)) != 0 || N_MID < 2)
      $error("csdec_mid: N_MID must be a power of two, at least 2");

   logic [ADDR_W-1:0] off;
   logic [7:0]        reg_sh;
   logic [IDX_W-1:0]  idx;

   always_comb begin
      off    = addr_i - base_i;
      reg_sh = 8'(MIN_SH) + 8'(sz_i);
      idx    = IDX_W'(off >> reg_sh);
      hit_o  = !io_i && ((off >> (reg_sh + 8'(IDX_W))) == '0);
      sel_o  = '0;
      b8_o   = 1'b0;
      if (hit_o) begin
         if (span_i) begin
            sel_o[0] = 1'b1;
            b8_o     = w8_i[0];
         end else begin
            sel_o[idx] = 1'b1;
            b8_o       = w8_i[idx];
         end
      end
   end
endmodule

// File: rtl/csdec_per.sv
module csdec_per #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned N_PER  = 6
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              io_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              space_io_i,
   output logic              hit_o,
   output logic [N_PER-1:0]  sel_o
);
   localparam int unsigned PIDX_W = (N_PER > 1) ? $clog2(N_PER) : 1;

   if (N_PER < 1 || N_PER > 64)
      $error("csdec_per: N_PER out of range");

   logic [ADDR_W-1:0] win;

   always_comb begin
      win   = (addr_i - base_i) >> csdec_pkg::PER_WIN_SH;
      hit_o = (io_i == space_io_i) && (win < ADDR_W'(N_PER));
      sel_o = '0;
      if (hit_o) sel_o[PIDX_W'(win)] = 1'b1;
   end
endmodule

// File: rtl/csdec_dram.sv
module csdec_dram #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned N_DRAM = 2,
   parameter int unsigned DSZ_W  = 5,
   parameter int unsigned WS_W   = 4
) (
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic                           io_i,
   input  logic [N_DRAM-1:0]              en_i,
   input  logic [N_DRAM-1:0][ADDR_W-1:0]  base_i,
   input  logic [N_DRAM-1:0][DSZ_W-1:0]   sz_i,
   input  logic [N_DRAM-1:0][WS_W-1:0]    ws_i,
   output logic                           hit_o,
   output logic [WS_W-1:0]                ws_o
);
   if (N_DRAM < 1)
      $error("csdec_dram: need at least one bank");

   logic [N_DRAM-1:0] bank_hit;

   for (genvar b = 0; b < N_DRAM; b++) begin : g_bank
      logic [ADDR_W-1:0] off;
      assign off         = addr_i - base_i[b];
      assign bank_hit[b] = en_i[b] && !io_i && ((off >> sz_i[b]) == '0);
   end

   always_comb begin
      ws_o = '0;
      for (int b = N_DRAM - 1; b >= 0; b--)
         if (bank_hit[b]) ws_o = ws_i[b];
      hit_o = |bank_hit;
   end
endmodule

// File: rtl/csdec_top.sv
module csdec_top #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned N_MID  = 4,
   parameter int unsigned N_PER  = 6,
   parameter int unsigned N_DRAM = 2,
   parameter int unsigned SZ_W   = 3,
   parameter int unsigned DSZ_W  = 5,
   parameter int unsigned WS_W   = 4
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic                           io_i,
   input  logic                           aphase_i,
   input  logic                           hold_i,
   input  logic [ADDR_W-1:0]              mid_base_i,
   input  logic [SZ_W-1:0]                mid_sz_i,
   input  logic [N_MID-1:0]               mid_w8_i,
   input  logic [WS_W-1:0]                mid_ws_i,
   input  logic                           mid_span_i,
   input  logic [ADDR_W-1:0]              per_base_i,
   input  logic                           per_io_i,
   input  logic [WS_W-1:0]                per_ws_i,
   input  logic [N_DRAM-1:0]              dram_en_i,
   input  logic [N_DRAM-1:0][ADDR_W-1:0]  dram_base_i,
   input  logic [N_DRAM-1:0][DSZ_W-1:0]   dram_sz_i,
   input  logic [N_DRAM-1:0][WS_W-1:0]    dram_ws_i,
   input  logic [ADDR_W-1:0]              hi_base_i,
   input  logic                           hi_dram_i,
   input  logic [WS_W-1:0]                base_ws_i,
   output logic [N_MID-1:0]               mid_cs_n_o,
   output logic [N_PER-1:0]               per_cs_n_o,
   output logic                           hi_cs_n_o,
   output logic                           dram_act_o,
   output logic                           bus8_o,
   output logic [WS_W-1:0]                ws_o
);
   if (ADDR_W < 12 || ADDR_W > 32)
      $error("csdec_top: ADDR_W out of range");
   if (WS_W < 1)
      $error("csdec_top: WS_W must be positive");

   // Captured access
   logic [ADDR_W-1:0] lat_addr;
   logic              lat_io;
   logic              lat_vld;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat_addr <= '0;
         lat_io   <= 1'b0;
         lat_vld  <= 1'b0;
      end else if (aphase_i) begin
         lat_addr <= addr_i;
         lat_io   <= io_i;
         lat_vld  <= 1'b1;
      end
   end

   // Decoders
   logic             mid_hit, mid_b8;
   logic [N_MID-1:0] mid_sel;
   logic             per_hit, per_live_hit;
   logic [N_PER-1:0] per_sel, per_live_sel;
   logic             dram_hit;
   logic [WS_W-1:0]  dram_ws;

   csdec_mid #(.ADDR_W(ADDR_W), .N_MID(N_MID), .SZ_W(SZ_W)) u_mid (
      .addr_i(lat_addr), .io_i(lat_io), .base_i(mid_base_i), .sz_i(mid_sz_i),
      .span_i(mid_span_i), .w8_i(mid_w8_i),
      .hit_o(mid_hit), .sel_o(mid_sel), .b8_o(mid_b8));

   csdec_per #(.ADDR_W(ADDR_W), .N_PER(N_PER)) u_per_lat (
      .addr_i(lat_addr), .io_i(lat_io), .base_i(per_base_i),
      .space_io_i(per_io_i), .hit_o(per_hit), .sel_o(per_sel));

   csdec_per #(.ADDR_W(ADDR_W), .N_PER(N_PER)) u_per_live (
      .addr_i(addr_i), .io_i(io_i), .base_i(per_base_i),
      .space_io_i(per_io_i), .hit_o(per_live_hit), .sel_o(per_live_sel));

   csdec_dram #(.ADDR_W(ADDR_W), .N_DRAM(N_DRAM), .DSZ_W(DSZ_W), .WS_W(WS_W)) u_dram (
      .addr_i(lat_addr), .io_i(lat_io), .en_i(dram_en_i), .base_i(dram_base_i),
      .sz_i(dram_sz_i), .ws_i(dram_ws_i), .hit_o(dram_hit), .ws_o(dram_ws));

   // Output resolution
   logic drive_ok, lat_ok, hi_hit;

   always_comb begin
      drive_ok = rst_ni && !hold_i;
      lat_ok   = drive_ok && lat_vld;
      hi_hit   = !lat_io && (lat_addr >= hi_base_i) && !hi_dram_i;

      mid_cs_n_o = lat_ok ? ~mid_sel : '1;
      hi_cs_n_o  = !(lat_ok && hi_hit);
      if (!drive_ok)
         per_cs_n_o = '1;
      else if (aphase_i)
         per_cs_n_o = per_live_hit ? ~per_live_sel : '1;
      else
         per_cs_n_o = lat_vld ? ~per_sel : '1;

      dram_act_o = lat_ok && dram_hit && !per_hit;
      bus8_o     = lat_vld && mid_hit && mid_b8 && !per_hit && !dram_hit;

      if (!lat_vld)
         ws_o = base_ws_i;
      else if (per_hit)
         ws_o = (dram_hit && dram_ws > per_ws_i) ? dram_ws : per_ws_i;
      else if (dram_hit)
         ws_o = dram_ws;
      else if (mid_hit)
         ws_o = mid_ws_i;
      else
         ws_o = base_ws_i;
   end

   // Assertions
   a_r1_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |-> (mid_cs_n_o == '1 && per_cs_n_o == '1 && hi_cs_n_o && !dram_act_o));

   a_r2_mid_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~mid_cs_n_o));

   a_r3_span_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mid_span_i |-> (mid_cs_n_o[N_MID-1:1] == '1));

   a_r5_per_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~per_cs_n_o));

   a_r7_per_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!aphase_i && per_cs_n_o != '1) |-> !dram_act_o);

   a_r8_ws_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!aphase_i && per_cs_n_o != '1) |-> (ws_o >= per_ws_i));

   a_r9_hi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_dram_i |-> hi_cs_n_o);
endmodule

// File: tb/sim_csdec_top.sv
module sim_csdec_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, io, aph, hold, mid_span, per_io, hi_dram;
   logic [19:0] addr, mid_base, per_base, hi_base;
   logic [2:0]  mid_sz;
   logic [3:0]  mid_w8, mid_ws, per_ws, base_ws;
   logic [1:0]  dram_en;
   logic [1:0][19:0] dram_base;
   logic [1:0][4:0]  dram_sz;
   logic [1:0][3:0]  dram_ws;
   logic [3:0]  mid_n;
   logic [5:0]  per_n;
   logic        hi_n, dram_act, b8;
   logic [3:0]  ws;

   csdec_top u0 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .io_i(io), .aphase_i(aph),
      .hold_i(hold), .mid_base_i(mid_base), .mid_sz_i(mid_sz), .mid_w8_i(mid_w8),
      .mid_ws_i(mid_ws), .mid_span_i(mid_span), .per_base_i(per_base),
      .per_io_i(per_io), .per_ws_i(per_ws), .dram_en_i(dram_en),
      .dram_base_i(dram_base), .dram_sz_i(dram_sz), .dram_ws_i(dram_ws),
      .hi_base_i(hi_base), .hi_dram_i(hi_dram), .base_ws_i(base_ws),
      .mid_cs_n_o(mid_n), .per_cs_n_o(per_n), .hi_cs_n_o(hi_n),
      .dram_act_o(dram_act), .bus8_o(b8), .ws_o(ws));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // Capture one access and leave the strobe low afterwards.
   task automatic access(input logic [19:0] a, input logic sp);
      @(negedge clk);
      addr = a; io = sp; aph = 1'b1;
      @(negedge clk);
      aph = 1'b0;
      #1;
   endtask

   task automatic chk_all(input string tag, input logic [3:0] em, input logic [5:0] ep,
                          input logic eh, input logic ed, input logic eb, input logic [3:0] ew);
      chk({tag, " mid"},  32'(mid_n), 32'(em));
      chk({tag, " per"},  32'(per_n), 32'(ep));
      chk({tag, " hi"},   32'(hi_n), 32'(eh));
      chk({tag, " dram"}, 32'(dram_act), 32'(ed));
      chk({tag, " b8"},   32'(b8), 32'(eb));
      chk({tag, " ws"},   32'(ws), 32'(ew));
   endtask

   typedef struct packed {
      logic [19:0] a;
      logic        sp;
      logic [3:0]  em;
      logic [5:0]  ep;
      logic        eh;
      logic        ed;
      logic        eb;
      logic [3:0]  ew;
   } vec_t;

   // Config: mid block 0x20000..0x21FFF (2 KB regions), w8=0101, mid ws 2;
   // peripheral base 0x30000 memory space, ws 1; bank0 0x30000 1 KB ws 3;
   // bank1 0x40000 64 KB ws 5; upper from 0xF0000; default ws 4.
   localparam vec_t VEC [13] = '{
      '{20'h20010, 1'b0, 4'b1110, 6'h3F, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 R4 R12 region0
      '{20'h20850, 1'b0, 4'b1101, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 R4 region1
      '{20'h21000, 1'b0, 4'b1011, 6'h3F, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 region2
      '{20'h21FFF, 1'b0, 4'b0111, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 last byte
      '{20'h22000, 1'b0, 4'b1111, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd4}, // R10 past block
      '{20'h1FFFF, 1'b0, 4'b1111, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd4}, // R10 below block
      '{20'h30450, 1'b0, 4'b1111, 6'h2F, 1'b1, 1'b0, 1'b0, 4'd1}, // R5 R8 window4
      '{20'h30120, 1'b0, 4'b1111, 6'h3D, 1'b1, 1'b0, 1'b0, 4'd3}, // R7 R8 overlap
      '{20'h30600, 1'b0, 4'b1111, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd4}, // R5 window6 absent
      '{20'h40010, 1'b0, 4'b1111, 6'h3F, 1'b1, 1'b1, 1'b0, 4'd5}, // R11 bank1
      '{20'hF1234, 1'b0, 4'b1111, 6'h3F, 1'b0, 1'b0, 1'b0, 4'd4}, // R9 upper
      '{20'h30120, 1'b1, 4'b1111, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd4}, // R5 wrong space
      '{20'h20010, 1'b1, 4'b1111, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd4}  // R2 I/O ignored
   };

   initial begin
      #(20 * 20000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; addr = 20'h30120; io = 1'b0; aph = 1'b1; hold = 1'b0;
      mid_base = 20'h20000; mid_sz = 3'd2; mid_w8 = 4'b0101; mid_ws = 4'd2;
      mid_span = 1'b0; per_base = 20'h30000; per_io = 1'b0; per_ws = 4'd1;
      dram_en = 2'b11; dram_base[0] = 20'h30000; dram_base[1] = 20'h40000;
      dram_sz[0] = 5'd10; dram_sz[1] = 5'd16; dram_ws[0] = 4'd3; dram_ws[1] = 4'd5;
      hi_base = 20'hF0000; hi_dram = 1'b0; base_ws = 4'd4;

      // R1: reset holds everything inactive even with a matching strobe
      repeat (3) @(negedge clk);
      #1 chk_all("R1 reset", 4'hF, 6'h3F, 1'b1, 1'b0, 1'b0, 4'd4);
      @(negedge clk);
      aph = 1'b0; rst_n = 1'b1;

      for (int i = 0; i < 13; i++) begin
         access(VEC[i].a, VEC[i].sp);
         chk_all($sformatf("vec%0d", i), VEC[i].em, VEC[i].ep, VEC[i].eh,
                 VEC[i].ed, VEC[i].eb, VEC[i].ew);
      end

      // R6: peripheral select valid before the capturing edge
      access(20'h22000, 1'b0);
      @(negedge clk);
      addr = 20'h30450; io = 1'b0; aph = 1'b1;
      #2;
      chk("R6 live per", 32'(per_n), 32'h2F);
      chk("R6 mid still idle", 32'(mid_n), 32'hF);
      @(negedge clk);
      aph = 1'b0;

      // R1: hold quiets a latched midrange access, release restores it
      access(20'h20010, 1'b0);
      hold = 1'b1; #1;
      chk("R1 hold mid", 32'(mid_n), 32'hF);
      access(20'h40010, 1'b0);
      chk("R1 hold dram", 32'(dram_act), 32'd0);
      hold = 1'b0; #1;
      chk("R1 release dram", 32'(dram_act), 32'd1);

      // R3 R4: whole-block mode
      mid_span = 1'b1;
      access(20'h21800, 1'b0);
      chk("R3 span sel", 32'(mid_n), 32'hE);
      chk("R4 span b8", 32'(b8), 32'd1);
      mid_w8 = 4'b1110; #1;
      chk("R4 span b8 bit0", 32'(b8), 32'd0);
      mid_span = 1'b0; #1;
      chk("R2 region3 restored", 32'(mid_n), 32'h7);

      // R8: peripheral count above DRAM count
      per_ws = 4'd6;
      access(20'h30120, 1'b0);
      chk("R8 max per", 32'(ws), 32'd6);
      chk("R7 dram off", 32'(dram_act), 32'd0);
      per_ws = 4'd1;

      // R11: bank disabled, no DRAM
      dram_en = 2'b01;
      access(20'h40010, 1'b0);
      chk("R11 bank off", 32'(dram_act), 32'd0);
      chk("R10 bank off ws", 32'(ws), 32'd4);
      dram_en = 2'b11;

      // R9: upper DRAM function negates upper select
      hi_dram = 1'b1;
      access(20'hF1234, 1'b0);
      chk("R9 hi off", 32'(hi_n), 32'd1);
      hi_dram = 1'b0; #1;
      chk("R9 hi back", 32'(hi_n), 32'd0);

      // R5: peripheral block in I/O space
      per_io = 1'b1;
      access(20'h30120, 1'b1);
      chk("R5 io per", 32'(per_n), 32'h3D);
      chk("R11 io no dram", 32'(dram_act), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule